// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block turns accesses from a 32-bit memory-mapped register bus into offsets in an internal register space. That space is wider than the bus can address directly. The bus sees a 4 KB region. Its lower three quarters map one-to-one onto internal offsets 0x000 to 0xBFF. The top quarter, from 0xC00 to 0xFFF, is a 1 KB window. In the window, a page number held in a control register supplies the upper internal offset bits, and the bus address supplies the offset inside the page.

Every access names a size in bytes: 1, 2 or 4. The decoder rejects an unsupported size or an unaligned address with a one-cycle error response. Accepted reads return the addressed bytes right-justified. Accepted writes touch only the addressed byte lanes. A small parameterised storage array stands in for the register file so that the block can be exercised end to end. The control register that holds the page number is a flop register of its own, and it is reachable like any other register.

Top module: `paged_csr_window`

## Requirements
- R1: A bus address below 0xC00 reaches the internal register whose byte offset equals that address.
- R2: A bus address from 0xC00 to 0xFFF reaches internal offset `{page, addr[9:0]}` (page as the upper 6 bits of a 16-bit offset). With page 0, window address 0xC00+k therefore reaches the same register as direct address k.
- R3: The control register is the 32-bit word at direct offset 0x000. Its bits [13:8] are the 6-bit page number, which resets to 0. All 32 control bits read back as last written.
- R4: A write that changes the page number applies to the very next access, including one on the following cycle.
- R5: `req_size` holds the access size as a byte count. The values 1, 2 and 4 are accepted, and every other value is rejected.
- R6: An access whose address is not a multiple of its size is rejected (a halfword with addr[0]=1, a word with addr[1:0]≠0).
- R7: A rejected access returns `rsp_err`=1 with `rsp_valid` for that one response, `rsp_rdata`=0, and changes no register, the page number included.
- R8: A byte or halfword write takes its data from the low bits of `req_wdata` and updates only the lanes it addresses, little-endian (the byte at addr[1:0]=k occupies word bits 8k+7:8k). The other bytes of the word are kept.
- R9: A byte or halfword read returns the addressed lanes in the low bits of `rsp_rdata`, with zeros above.
- R10: Each request accepted on a clock edge produces exactly one response on the following cycle. Idle cycles produce none. Write responses carry zero data. A read issued right after a write to the same register returns the new value.
- R11: An aligned access whose internal word index lies beyond the storage depth (internal offset 0x2000 and above with default parameters) is not an error. It reads zero, and its writes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Bus byte address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, right-justified, zero on writes and errors |

## Verification
The hardest case to reach from the ports is a page change that lands in the very cycle before a windowed access. A page number set by a byte write to the control register has to redirect the next request, and the page number is visible only through what that request returns. The stimulus issues control writes back to back with window reads and writes across several pages. It sets up data at known internal offsets beforehand, so a stale page returns a distinguishable word. It also uses page 0 to show that the window aliases direct offsets, and page 63 to reach offsets beyond the storage.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

   typedef enum logic [2:0] {
      SZ_BYTE = 3'd1,
      SZ_HALF = 3'd2,
      SZ_WORD = 3'd4
   } size_e;

   typedef logic [3:0] lane_en_t;

   function automatic logic [31:0] size_mask(input logic [2:0] sz);
      case (sz)
         SZ_BYTE: size_mask = 32'h0000_00FF;
         SZ_HALF: size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic lane_en_t size_lanes(input logic [2:0] sz);
      case (sz)
         SZ_BYTE: size_lanes = 4'b0001;
         SZ_HALF: size_lanes = 4'b0011;
         default: size_lanes = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/pcw_decode.sv
module pcw_decode
   import pcw_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int BOUNDARY = 'hC00,
   parameter int PAGE_W   = 6,
   parameter int INPAGE_W = 10,
   parameter int INT_W    = PAGE_W + INPAGE_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic [PAGE_W-1:0] page,
   output logic [INT_W-1:0]  int_off,
   output logic              err,
   output lane_en_t          lane_en
);

   localparam logic [ADDR_W-1:0] BOUND_A = ADDR_W'(BOUNDARY);

   logic in_window;
   logic size_ok;
   logic align_ok;

   assign in_window = (addr >= BOUND_A);

   always_comb begin
      if (in_window) int_off = {page, addr[INPAGE_W-1:0]};
      else           int_off = INT_W'(addr);
   end

   always_comb begin
      size_ok  = 1'b0;
      align_ok = 1'b1;
      case (size)
         SZ_BYTE: size_ok = 1'b1;
         SZ_HALF: begin size_ok = 1'b1; align_ok = ~addr[0]; end
         SZ_WORD: begin size_ok = 1'b1; align_ok = (addr[1:0] == 2'b00); end
         default: size_ok = 1'b0;
      endcase
   end

   assign err     = ~(size_ok & align_ok);
   assign lane_en = size_lanes(size) << addr[1:0];

endmodule

// File: rtl/pcw_lanes.sv
module pcw_lanes
   import pcw_pkg::*;
(
   input  logic [1:0]  lane,
   input  logic [2:0]  size,
   input  logic [31:0] wdata,
   input  logic [31:0] rword,
   output logic [31:0] wdata_sh,
   output logic [31:0] rdata
);

   logic [4:0] shamt;

   assign shamt    = {lane, 3'b000};
   assign wdata_sh = wdata << shamt;
   assign rdata    = (rword >> shamt) & size_mask(size);

endmodule

// File: rtl/pcw_regfile.sv
module pcw_regfile
   import pcw_pkg::*;
#(
   parameter int WIDX_W      = 14,
   parameter int DEPTH_WORDS = 2048,
   parameter int CTRL_WORD   = 0,
   parameter int PSEL_LSB    = 8,
   parameter int PAGE_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] word_idx,
   input  lane_en_t          lane_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rword,
   output logic [PAGE_W-1:0] page_sel
);

   localparam int STORE_AW = $clog2(DEPTH_WORDS);
   localparam logic [WIDX_W-1:0] CTRL_IDX  = WIDX_W'(CTRL_WORD);
   localparam logic [WIDX_W-1:0] DEPTH_IDX = WIDX_W'(DEPTH_WORDS);

   logic                is_ctrl;
   logic                in_store;
   logic [STORE_AW-1:0] store_idx;
   logic [31:0]         ctrl_q;
   logic [31:0]         store_word;

   assign is_ctrl   = (word_idx == CTRL_IDX);
   assign in_store  = (word_idx < DEPTH_IDX);
   assign store_idx = word_idx[STORE_AW-1:0];

   for (genvar l = 0; l < 4; l++) begin : g_lane
      logic [7:0] mem [DEPTH_WORDS];

      always_ff @(posedge clk) begin
         if (!rst_n)                            ctrl_q[8*l +: 8] <= 8'h00;
         else if (wr_en && is_ctrl && lane_en[l]) ctrl_q[8*l +: 8] <= wdata[8*l +: 8];
      end

      always_ff @(posedge clk) begin
         if (wr_en && !is_ctrl && in_store && lane_en[l])
            mem[store_idx] <= wdata[8*l +: 8];
      end

      assign store_word[8*l +: 8] = mem[store_idx];
   end

   always_comb begin
      if (is_ctrl)       rword = ctrl_q;
      else if (in_store) rword = store_word;
      else               rword = '0;
   end

   assign page_sel = ctrl_q[PSEL_LSB +: PAGE_W];

endmodule

// File: rtl/paged_csr_window.sv
module paged_csr_window
   import pcw_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BOUNDARY    = 'hC00,
   parameter int PAGE_W      = 6,
   parameter int INPAGE_W    = 10,
   parameter int DEPTH_WORDS = 2048,
   parameter int CTRL_OFF    = 'h000,
   parameter int PSEL_LSB    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata
);

   localparam int INT_W  = PAGE_W + INPAGE_W;
   localparam int WIDX_W = INT_W - 2;

   if (BOUNDARY + (1 << INPAGE_W) != (1 << ADDR_W)) begin : g_bad_window
      $error("window must fill the bus space above the boundary");
   end
   if (ADDR_W > INT_W) begin : g_bad_width
      $error("internal offset narrower than bus address");
   end
   if (CTRL_OFF % 4 != 0 || CTRL_OFF >= BOUNDARY) begin : g_bad_ctrl
      $error("control register must be word aligned and directly addressed");
   end
   if (PSEL_LSB + PAGE_W > 32) begin : g_bad_psel
      $error("page field exceeds control register");
   end
   if (DEPTH_WORDS < 2 || DEPTH_WORDS >= (1 << WIDX_W)) begin : g_bad_depth
      $error("storage depth out of range");
   end

   logic [INT_W-1:0]  int_off;
   logic              dec_err;
   lane_en_t          lane_en;
   logic [PAGE_W-1:0] page_sel;
   logic [31:0]       rword;
   logic [31:0]       wdata_sh;
   logic [31:0]       rdata_al;
   logic              wr_en;

   pcw_decode #(
      .ADDR_W   (ADDR_W),
      .BOUNDARY (BOUNDARY),
      .PAGE_W   (PAGE_W),
      .INPAGE_W (INPAGE_W),
      .INT_W    (INT_W)
   ) u_decode (
      .addr    (req_addr),
      .size    (req_size),
      .page    (page_sel),
      .int_off (int_off),
      .err     (dec_err),
      .lane_en (lane_en)
   );

   pcw_lanes u_lanes (
      .lane     (int_off[1:0]),
      .size     (req_size),
      .wdata    (req_wdata),
      .rword    (rword),
      .wdata_sh (wdata_sh),
      .rdata    (rdata_al)
   );

   assign wr_en = req_valid & req_write & ~dec_err;

   pcw_regfile #(
      .WIDX_W      (WIDX_W),
      .DEPTH_WORDS (DEPTH_WORDS),
      .CTRL_WORD   (CTRL_OFF / 4),
      .PSEL_LSB    (PSEL_LSB),
      .PAGE_W      (PAGE_W)
   ) u_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .word_idx (int_off[INT_W-1:2]),
      .lane_en  (lane_en),
      .wdata    (wdata_sh),
      .rword    (rword),
      .page_sel (page_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & dec_err;
         rsp_rdata <= (req_valid && !req_write && !dec_err) ? rdata_al : '0;
      end
   end

endmodule

// File: rtl/paged_csr_window_chk.sv
module paged_csr_window_chk #(
   parameter int PAGE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_lo,
   input logic [2:0]        req_size,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata,
   input logic [PAGE_W-1:0] page_sel
);

   logic bad_size;
   logic misaligned;

   assign bad_size   = !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4);
   assign misaligned = (req_size == 3'd2 && req_lo[0]) ||
                       (req_size == 3'd4 && req_lo != 2'b00);

   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r10_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> rsp_rdata == 32'h0);

   a_r7_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

   a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == 32'h0);

   a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (bad_size || misaligned) |=> $stable(page_sel));

   a_r5_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && bad_size |=> rsp_err);

   a_r6_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && misaligned |=> rsp_err);

   a_r9_byte_fill: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_size == 3'd1 |=> rsp_rdata[31:8] == 24'h0);

   a_r9_half_fill: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_size == 3'd2 |=> rsp_rdata[31:16] == 16'h0);

endmodule

bind paged_csr_window paged_csr_window_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_lo    (req_addr[1:0]),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .page_sel  (page_sel)
);

// File: tb/paged_csr_window_bench.sv
`timescale 1ns/1ps
module paged_csr_window_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic        err;
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] mem_m [int];
   logic [31:0] ctrl_m = 32'h0;

   always #4 clk = ~clk;

   paged_csr_window u_paged_csr_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual {err,data}=%h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected response", {rsp_err, rsp_rdata}, 33'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({rsp_err, rsp_rdata} === {e.err, e.data}, e.tag,
                  {rsp_err, rsp_rdata}, {e.err, e.data});
         end
      end
   end

   // driver: model the requirement, push expectation, drive one cycle
   task automatic acc(input bit wr, input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, input string tag);
      exp_t        e;
      int          s;
      int          off;
      int          w;
      int          ln;
      logic [31:0] word;
      logic [31:0] msk;
      bit          err;
      s   = int'(sz);
      err = !(s == 1 || s == 2 || s == 4);
      if (!err && ((int'(a) % s) != 0)) err = 1'b1;
      if (a >= 12'hC00) off = (int'(ctrl_m[13:8]) << 10) | (int'(a) & 'h3FF);
      else              off = int'(a);
      w  = off >> 2;
      ln = int'(a) & 3;
      if (w == 0)                           word = ctrl_m;
      else if (w < 2048 && mem_m.exists(w)) word = mem_m[w];
      else                                  word = 32'h0;
      msk = (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      e.err = err;
      e.tag = tag;
      e.data = 32'h0;
      if (!err) begin
         if (wr) begin
            for (int b = 0; b < 4; b++)
               if (b >= ln && b < ln + s) word[8*b +: 8] = wd[8*(b-ln) +: 8];
            if (w == 0)         ctrl_m = word;
            else if (w < 2048)  mem_m[w] = word;
         end else begin
            e.data = (word >> (8*ln)) & msk;
         end
      end
      exp_q.push_back(e);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_size  = sz;
      req_wdata = wd;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      req_write = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 20000);
      n_bad++;
      $display("FAIL R10 watchdog: actual run still busy, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R10 reset quiet",
            {rsp_err, 31'h0, rsp_valid}, 33'h0);
      rst_n = 1'b1;
      @(negedge clk);

      acc(0, 12'h000, 3'd4, 0, "R3 control reset value");
      // R1 direct path, R10 read right after write
      acc(1, 12'h010, 3'd4, 32'hA1B2_C3D4, "R1 direct write");
      acc(0, 12'h010, 3'd4, 0, "R1 R10 direct read after write");
      acc(1, 12'h400, 3'd4, 32'h1111_2222, "R1 direct write 0x400");
      // R4 page change used at once
      acc(1, 12'h000, 3'd4, 32'h0000_0100, "R3 select page 1");
      acc(0, 12'hC00, 3'd4, 0, "R4 R2 page 1 window read");
      acc(1, 12'hC10, 3'd4, 32'h3333_4444, "R2 page 1 window write");
      acc(1, 12'h000, 3'd2, 32'h0000_0000, "R3 back to page 0");
      acc(0, 12'hC10, 3'd4, 0, "R2 page 0 aliases direct");
      acc(0, 12'hC00, 3'd4, 0, "R2 page 0 reaches control");
      // R8 byte write to the page field
      acc(1, 12'h001, 3'd1, 32'h0000_0005, "R8 byte write page 5");
      acc(1, 12'hC08, 3'd4, 32'hCAFE_F00D, "R2 page 5 write");
      acc(1, 12'h001, 3'd1, 32'h0000_0001, "R4 switch to page 1");
      acc(0, 12'hC10, 3'd4, 0, "R4 page 1 read after switch");
      acc(1, 12'h001, 3'd1, 32'h0000_0005, "R4 switch to page 5");
      acc(0, 12'hC08, 3'd4, 0, "R2 page 5 readback");
      // R11 beyond storage
      acc(1, 12'h001, 3'd1, 32'h0000_003F, "R3 page 63");
      acc(1, 12'hC20, 3'd4, 32'hDEAD_BEEF, "R11 write beyond storage");
      acc(0, 12'hC20, 3'd4, 0, "R11 read beyond storage");
      // R3 all control bits
      acc(1, 12'h000, 3'd4, 32'hFFFF_FFFF, "R3 control all ones");
      acc(0, 12'h000, 3'd4, 0, "R3 control readback");
      acc(1, 12'h000, 3'd4, 32'h0000_0000, "R3 control clear");
      // R8 lanes, R9 right-justified reads
      acc(1, 12'h020, 3'd4, 32'h0000_0000, "R8 clear word");
      acc(1, 12'h021, 3'd1, 32'hFFFF_FF5A, "R8 byte lane 1");
      acc(0, 12'h020, 3'd4, 0, "R8 word after byte");
      acc(1, 12'h022, 3'd2, 32'hFFFF_BEEF, "R8 half upper lanes");
      acc(0, 12'h020, 3'd4, 0, "R8 word after half");
      acc(0, 12'h023, 3'd1, 0, "R9 byte lane 3");
      acc(0, 12'h021, 3'd1, 0, "R9 byte lane 1");
      acc(0, 12'h022, 3'd2, 0, "R9 half upper");
      acc(0, 12'h020, 3'd2, 0, "R9 half lower");
      // R6 and R7 rejections
      acc(0, 12'h021, 3'd2, 0, "R6 half misaligned");
      acc(1, 12'h012, 3'd4, 32'h0000_0099, "R6 word misaligned write");
      acc(0, 12'h010, 3'd4, 0, "R7 word unchanged");
      acc(1, 12'h002, 3'd4, 32'hFFFF_FFFF, "R7 misaligned control write");
      // R5 sizes
      acc(0, 12'h010, 3'd3, 0, "R5 size 3");
      acc(1, 12'h000, 3'd0, 32'h0000_3F00, "R5 size 0 control write");
      acc(1, 12'h004, 3'd7, 32'h1234_5678, "R5 size 7");
      acc(0, 12'h000, 3'd4, 0, "R7 control unchanged");
      acc(0, 12'hC10, 3'd4, 0, "R7 page still 0");

      idle(2);
      check(rsp_valid == 1'b0, "R10 idle no response", {32'h0, rsp_valid}, 33'h0);
      idle(3);
      check(exp_q.size() == 0, "R10 all responses seen",
            33'(exp_q.size()), 33'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule